// File: doc/BRIEF.md
# Converter Start and Result Window Controller

This block is the digital control that sits in front of an 8-bit successive-approximation converter. Software chooses one of five start sources: a register command, the overflow of one of three timers, or a pin driven from outside the chip. When the chosen source fires and the converter is idle and enabled, the block sends the converter a start pulse one cycle long. It then holds a busy indication until the converter returns its result with a valid strobe.

On completion the block latches the sample into a result register and sets a sticky completion flag. That flag drives an interrupt line when software has allowed it. The same sample also goes to a window comparator with programmable inclusive bounds. That comparator sets a separate sticky flag, which is also its interrupt request, only when the sample meets the chosen policy: inside the window or outside it. A processor can therefore leave the converter sampling in the background and be disturbed only by samples that break policy.

Top module: `adc_winctl`

## Requirements
- R1: The source select `trig_sel` uses these codes: 0 is `sw_start`, 1 is `tmr0_ovf`, 2 is `tmr1_ovf`, 3 is `tmr2_ovf` and 4 is the synchronized rising edge of `ext_start`. A selected trigger that is high in a cycle where the block is enabled and not busy makes `conv_start` high in the next cycle. Triggers from sources that are not selected have no effect.
- R2: `conv_start` is high for exactly one cycle. `busy` rises together with it and stays high until the cycle after the converter's `conv_valid`.
- R3: A trigger that arrives while `busy` is high is ignored and produces no start pulse.
- R4: While `enable` is low, no start pulse is issued.
- R5: A `conv_valid` that arrives while busy latches `conv_data` into `result` on the next cycle. A `conv_valid` that arrives while idle changes neither `result` nor any flag.
- R6: `done_flag` is set by each completion and stays set until a one is written to `done_clr`. A completion in the same cycle as a clear leaves the flag set.
- R7: `done_irq` is high only while both `done_flag` and `done_ie` are high.
- R8: The window test is inclusive: a sample is inside when `win_lo` ≤ sample ≤ `win_hi`, and outside is the exact complement. With `win_inside` set to 1, a completion sets `win_irq` when the sample is inside. With `win_inside` set to 0, it sets `win_irq` when the sample is outside. In every other case the flag is left unchanged.
- R9: `win_irq` is sticky until a one is written to `win_clr`. A hit in the same cycle as a clear leaves it set.
- R10: `ext_start` passes through two synchronizer flops and then an edge detector. A rise that is first sampled at clock edge 1 gives `conv_start` high after edge 3.
- R11: Select codes 5, 6 and 7 choose no source, so no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; starts are blocked while low |
| trig_sel | input | 3 | Start source select |
| sw_start | input | 1 | Software start command, one-cycle pulse |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| ext_start | input | 1 | Asynchronous external start input |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | 8 | Converter result |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Latched sample |
| done_flag | output | 1 | Sticky completion flag |
| done_clr | input | 1 | Write-one clear for done_flag |
| done_ie | input | 1 | Completion interrupt enable |
| done_irq | output | 1 | Completion interrupt |
| win_lo | input | 8 | Lower window bound, inclusive |
| win_hi | input | 8 | Upper window bound, inclusive |
| win_inside | input | 1 | 1: flag samples inside the window; 0: flag samples outside it |
| win_clr | input | 1 | Write-one clear for win_irq |
| win_irq | output | 1 | Sticky window interrupt |

## Verification
If the busy state is wrong, `conv_start` shows it within one cycle: a second pulse appears, or an expected pulse is missing, when a trigger is offered during a conversion or just after the strobe. A fault in the window decision or in a bound edge shows on `win_irq` in the cycle after the strobe. The samples equal to `win_lo` and to `win_hi` are the ones that expose an off-by-one error. Faults in the synchronizer depth or the edge detector shift the external-start pulse by whole cycles, so the bench measures that pulse against an exact edge count.

// File: rtl/adc_winctl_pkg.sv
package adc_winctl_pkg;
   typedef enum logic [2:0] {
      SRC_CMD  = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_TMR1 = 3'd2,
      SRC_TMR2 = 3'd3,
      SRC_PIN  = 3'd4
   } start_src_e;
endpackage

// File: rtl/adc_trig_mux.sv
module adc_trig_mux
   import adc_winctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       cmd,
   input  logic       t0,
   input  logic       t1,
   input  logic       t2,
   input  logic       pin_async,
   output logic       trig
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pin_rise;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= pin_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   assign pin_rise = sync_q[LAST] & ~prev_q;

   always_comb begin
      case (sel)
         SRC_CMD:  trig = cmd;
         SRC_TMR0: trig = t0;
         SRC_TMR1: trig = t1;
         SRC_TMR2: trig = t2;
         SRC_PIN:  trig = pin_rise;
         default:  trig = 1'b0;
      endcase
   end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic trig,
   input  logic valid,
   output logic start,
   output logic busy,
   output logic capture
);
   logic fire;
   logic start_q;
   logic busy_q;

   assign fire    = enable & trig & ~busy_q;
   assign capture = valid & busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         start_q <= fire;
         if (fire)         busy_q <= 1'b1;
         else if (capture) busy_q <= 1'b0;
      end
   end

   assign start = start_q;
   assign busy  = busy_q;
endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] sample,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   input  logic              want_inside,
   output logic              hit
);
   logic in_range;

   assign in_range = (sample >= lo) && (sample <= hi);
   assign hit      = want_inside ? in_range : ~in_range;
endmodule

// File: rtl/adc_winctl.sv
module adc_winctl #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [2:0]        trig_sel,
   input  logic              sw_start,
   input  logic              tmr0_ovf,
   input  logic              tmr1_ovf,
   input  logic              tmr2_ovf,
   input  logic              ext_start,
   output logic              conv_start,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_data,
   output logic              busy,
   output logic [DATA_W-1:0] result,
   output logic              done_flag,
   input  logic              done_clr,
   input  logic              done_ie,
   output logic              done_irq,
   input  logic [DATA_W-1:0] win_lo,
   input  logic [DATA_W-1:0] win_hi,
   input  logic              win_inside,
   input  logic              win_clr,
   output logic              win_irq
);
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic              trig;
   logic              capture;
   logic              hit;
   logic [DATA_W-1:0] result_q;
   logic              done_q;
   logic              win_q;

   adc_trig_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (trig_sel),
      .cmd       (sw_start),
      .t0        (tmr0_ovf),
      .t1        (tmr1_ovf),
      .t2        (tmr2_ovf),
      .pin_async (ext_start),
      .trig      (trig)
   );

   adc_conv_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .trig    (trig),
      .valid   (conv_valid),
      .start   (conv_start),
      .busy    (busy),
      .capture (capture)
   );

   adc_win_cmp #(.DATA_W(DATA_W)) u_cmp (
      .sample      (conv_data),
      .lo          (win_lo),
      .hi          (win_hi),
      .want_inside (win_inside),
      .hit         (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         done_q   <= 1'b0;
         win_q    <= 1'b0;
      end else begin
         if (capture) result_q <= conv_data;

         if (capture)       done_q <= 1'b1;
         else if (done_clr) done_q <= 1'b0;

         if (capture && hit) win_q <= 1'b1;
         else if (win_clr)   win_q <= 1'b0;
      end
   end

   assign result    = result_q;
   assign done_flag = done_q;
   assign done_irq  = done_q & done_ie;
   assign win_irq   = win_q;
endmodule

// File: rtl/adc_winctl_chk.sv
module adc_winctl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              conv_start,
   input logic              conv_valid,
   input logic [DATA_W-1:0] conv_data,
   input logic              busy,
   input logic [DATA_W-1:0] result,
   input logic              done_flag,
   input logic              done_clr,
   input logic              done_irq,
   input logic              win_irq,
   input logic              win_clr
);
   // R2
   start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   // R3
   no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !conv_valid |=> !conv_start);

   // R4
   no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !conv_start);

   // R5
   result_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && conv_valid |=> result == $past(conv_data));

   // R5
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(result));

   // R6
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && conv_valid |=> done_flag);

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag && !done_clr |=> done_flag);

   // R7
   done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> done_flag);

   // R9
   win_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_irq && !win_clr |=> win_irq);
endmodule

bind adc_winctl adc_winctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .conv_start (conv_start),
   .conv_valid (conv_valid),
   .conv_data  (conv_data),
   .busy       (busy),
   .result     (result),
   .done_flag  (done_flag),
   .done_clr   (done_clr),
   .done_irq   (done_irq),
   .win_irq    (win_irq),
   .win_clr    (win_clr)
);

// File: tb/adc_winctl_bench.sv
module adc_winctl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [2:0] trig_sel = 3'd0;
   logic       sw_start = 1'b0, tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tmr2_ovf = 1'b0;
   logic       ext_start = 1'b0;
   logic       conv_start;
   logic       conv_valid = 1'b0;
   logic [7:0] conv_data = 8'd0;
   logic       busy;
   logic [7:0] result;
   logic       done_flag;
   logic       done_clr = 1'b0, done_ie = 1'b0;
   logic       done_irq;
   logic [7:0] win_lo = 8'd0, win_hi = 8'd0;
   logic       win_inside = 1'b1, win_clr = 1'b0;
   logic       win_irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   adc_winctl u_adc_winctl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .trig_sel(trig_sel),
      .sw_start(sw_start), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
      .tmr2_ovf(tmr2_ovf), .ext_start(ext_start), .conv_start(conv_start),
      .conv_valid(conv_valid), .conv_data(conv_data), .busy(busy),
      .result(result), .done_flag(done_flag), .done_clr(done_clr),
      .done_ie(done_ie), .done_irq(done_irq), .win_lo(win_lo),
      .win_hi(win_hi), .win_inside(win_inside), .win_clr(win_clr),
      .win_irq(win_irq)
   );

   // {lo, hi, inside, sample, expected window hit}
   localparam logic [25:0] VECS [9] = '{
      {8'd10, 8'd20,  1'b1, 8'd10,  1'b1},
      {8'd10, 8'd20,  1'b1, 8'd20,  1'b1},
      {8'd10, 8'd20,  1'b1, 8'd9,   1'b0},
      {8'd10, 8'd20,  1'b1, 8'd21,  1'b0},
      {8'd10, 8'd20,  1'b0, 8'd21,  1'b1},
      {8'd10, 8'd20,  1'b0, 8'd15,  1'b0},
      {8'd0,  8'd255, 1'b0, 8'd0,   1'b0},
      {8'd30, 8'd20,  1'b1, 8'd25,  1'b0},
      {8'd30, 8'd20,  1'b0, 8'd25,  1'b1}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic respond(input logic [7:0] d);
      tick();
      tick();
      conv_valid = 1'b1;
      conv_data  = d;
      tick();
      conv_valid = 1'b0;
   endtask

   task automatic clear_flags();
      done_clr = 1'b1;
      win_clr  = 1'b1;
      tick();
      done_clr = 1'b0;
      win_clr  = 1'b0;
   endtask

   task automatic pulse_src(input int src);
      case (src)
         0: sw_start = 1'b1;
         1: tmr0_ovf = 1'b1;
         2: tmr1_ovf = 1'b1;
         default: tmr2_ovf = 1'b1;
      endcase
      tick();
      sw_start = 1'b0; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; tmr2_ovf = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      // Reset state
      chk("R2 reset conv_start", int'(conv_start), 0);
      chk("R2 reset busy", int'(busy), 0);
      chk("R5 reset result", int'(result), 0);
      chk("R6 reset done_flag", int'(done_flag), 0);
      chk("R9 reset win_irq", int'(win_irq), 0);
      rst_n = 1'b1;
      enable = 1'b1;
      tick();

      // Vector table: window policy and result latching
      foreach (VECS[i]) begin
         win_lo     = VECS[i][25:18];
         win_hi     = VECS[i][17:10];
         win_inside = VECS[i][9];
         trig_sel   = 3'd0;
         pulse_src(0);
         chk("R1 start from command", int'(conv_start), 1);
         respond(VECS[i][8:1]);
         chk("R5 result latched", int'(result), int'(VECS[i][8:1]));
         chk("R6 done set", int'(done_flag), 1);
         chk("R8 window decision", int'(win_irq), int'(VECS[i][0]));
         chk("R2 busy cleared", int'(busy), 0);
         clear_flags();
         chk("R6 done cleared", int'(done_flag), 0);
         chk("R9 window cleared", int'(win_irq), 0);
      end

      // R1: each timer source, with an unselected source first
      for (int s = 1; s < 4; s++) begin
         trig_sel = 3'(s);
         pulse_src((s == 1) ? 2 : 1);
         chk("R1 unselected source ignored", int'(conv_start), 0);
         pulse_src(s);
         chk("R1 selected timer starts", int'(conv_start), 1);
         respond(8'd1);
      end
      clear_flags();

      // R10: external start latency
      trig_sel  = 3'd4;
      ext_start = 1'b1;
      tick();
      chk("R10 edge 1 no start", int'(conv_start), 0);
      tick();
      chk("R10 edge 2 no start", int'(conv_start), 0);
      tick();
      chk("R10 edge 3 start", int'(conv_start), 1);
      tick();
      chk("R10 level held gives one pulse", int'(conv_start), 0);
      respond(8'd2);
      ext_start = 1'b0;
      tick(); tick(); tick(); tick();
      chk("R10 falling edge no start", int'(busy), 0);

      // R11: unused select codes
      for (int c = 5; c < 8; c++) begin
         trig_sel = 3'(c);
         sw_start = 1'b1; tmr0_ovf = 1'b1; tmr1_ovf = 1'b1; tmr2_ovf = 1'b1;
         tick();
         sw_start = 1'b0; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; tmr2_ovf = 1'b0;
         tick();
         chk("R11 unused code no start", int'(busy), 0);
      end

      // R3: trigger while busy
      trig_sel = 3'd0;
      pulse_src(0);
      pulse_src(0);
      chk("R3 no second start", int'(conv_start), 0);
      chk("R3 still busy", int'(busy), 1);
      respond(8'd3);

      // R4: disabled
      enable = 1'b0;
      pulse_src(0);
      chk("R4 no start when off", int'(conv_start), 0);
      chk("R4 not busy when off", int'(busy), 0);
      enable = 1'b1;

      // R5: strobe while idle
      clear_flags();
      conv_valid = 1'b1;
      conv_data  = 8'h55;
      tick();
      conv_valid = 1'b0;
      chk("R5 idle strobe result", int'(result), 3);
      chk("R5 idle strobe flag", int'(done_flag), 0);

      // R7: interrupt enable
      pulse_src(0);
      respond(8'd4);
      done_ie = 1'b0;
      #1;
      chk("R7 irq masked", int'(done_irq), 0);
      done_ie = 1'b1;
      #1;
      chk("R7 irq enabled", int'(done_irq), 1);

      // R6 and R9: set wins over clear
      win_lo = 8'd0; win_hi = 8'd100; win_inside = 1'b1;
      pulse_src(0);
      tick();
      conv_valid = 1'b1;
      conv_data  = 8'd50;
      done_clr   = 1'b1;
      win_clr    = 1'b1;
      tick();
      conv_valid = 1'b0;
      done_clr   = 1'b0;
      win_clr    = 1'b0;
      chk("R6 set wins over clear", int'(done_flag), 1);
      chk("R9 hit wins over clear", int'(win_irq), 1);
      clear_flags();
      chk("R7 irq drops with flag", int'(done_irq), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule